// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron

This block is one digital spiking neuron. It holds a signed membrane potential and moves it only when a step strobe arrives. On each step it works out one forward-Euler increment. The increment is the injected current times the membrane resistance, minus the distance of the potential from a programmable resting level, and that difference is scaled by a programmable step-to-time-constant gain. When the updated potential reaches a programmable threshold, the neuron fires. It emits a spike pulse lasting one clock and drops its potential back to the resting level.

The configuration inputs are resting level, threshold, resistance and gain. They are captured into shadow registers in every cycle where the step strobe is low. A step therefore always works with the settings seen before it. The arithmetic keeps full precision internally, rounds toward negative infinity, and clamps the result to the signed range of the potential instead of letting it wrap.

Top module: `lif_neuron`

## Requirements
- R1: While `rst` is high at a clock edge, the potential loads `cfgRest` and `spike` is cleared. After release, `potential` equals the resting level and `spike` is 0.
- R2: Each clock edge with `stepEn` high applies V += floor(((floor(I*R/256)) - (V - rest)) * gain / 65536). Potential, current, rest and threshold are signed Q8.8. Resistance is unsigned Q8.8. Gain is unsigned Q0.16. The potential does not change in cycles without a step. With rest -70.0, R 10.0, gain 655 and I 2.5, the first step from rest gives raw value -17857 (about -69.75).
- R3: With zero current, the potential starts at rest and stays exactly at rest over any number of steps.
- R4: A step fires when its updated potential is greater than or equal to the threshold. Equality fires. One LSB below the threshold does not.
- R5: On a firing step the potential becomes the resting level, and the next step integrates from the resting level.
- R6: `spike` is high for exactly the one clock that follows a step edge whose update fired, and is low in every other cycle.
- R7: With the default settings (rest -70, threshold -50, R 10, gain 655) and I 2.5, the neuron fires periodically, with an equal number of steps between consecutive spikes.
- R8: With the default settings and I 1.5, the neuron never fires.
- R9: An update beyond the signed 16-bit range clamps to -32768 or +32767 and does not wrap.
- R10: Configuration values applied while `stepEn` is high are not used by that step. They take effect on a step that follows at least one cycle with `stepEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Time-step strobe, one update per high cycle |
| inCurrent | input | 16 | Injected current, signed Q8.8 |
| cfgRest | input | 16 | Resting level, signed Q8.8 |
| cfgThresh | input | 16 | Firing threshold, signed Q8.8 |
| cfgResist | input | 16 | Membrane resistance, unsigned Q8.8 |
| cfgGain | input | 16 | Step-to-time-constant gain, unsigned Q0.16 |
| spike | output | 1 | One-clock spike pulse |
| potential | output | 16 | Membrane potential, signed Q8.8 |

## Verification
The update is driven with four input patterns. Zero current shows whether the leak term settles exactly at a nonzero rest instead of zero. A supra-threshold current of 2.5 tests the rounding, the reset to rest and the periodic firing interval. A sub-threshold current of 1.5 shows whether the fixed-point steady state stays below threshold. A large negative drive with a near-unity gain separates clamping from wraparound. Hand-picked half-gain cases land the update exactly on the threshold and one LSB under it, which tells greater-or-equal apart from greater-than. A configuration change issued in the same cycle as a step shows whether the shadow registers shield that step.

// File: rtl/lif_pkg.sv
package lif_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic resetPot;  // load resting level into the potential
    logic loadCfg;   // capture configuration into shadow registers
    logic doStep;    // perform one Euler update
  } lifStrobes_t;
endpackage

// File: rtl/lif_ctrl.sv
module lif_ctrl
  import lif_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        stepEn,
  input  logic        fire,
  output lifStrobes_t st,
  output logic        spike
);

  always_comb begin
    st.resetPot = rst;
    st.loadCfg  = rst | ~stepEn;
    st.doStep   = stepEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) spike <= 1'b0;
    else     spike <= fire;
  end

  AST_SPIKE_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    spike |-> $past(stepEn)); // R6

  AST_FIRE_MAKES_SPIKE: assert property (@(posedge clk) disable iff (rst)
    (st.doStep && fire) |=> spike); // R6

endmodule

// File: rtl/lif_datapath.sv
module lif_datapath
  import lif_pkg::*;
#(
  parameter int DW        = 16,
  parameter int FRAC      = 8,
  parameter int GW        = 16,
  parameter bit USE_SHIFT = 1'b0
)(
  input  logic                 clk,
  input  lifStrobes_t          st,
  input  logic signed [DW-1:0] inCurrent,
  input  logic signed [DW-1:0] cfgRest,
  input  logic signed [DW-1:0] cfgThresh,
  input  logic        [DW-1:0] cfgResist,
  input  logic        [GW-1:0] cfgGain,
  output logic                 fire,
  output logic signed [DW-1:0] potential
);

  localparam int PW  = 2*DW + 1;          // current x resistance
  localparam int DFW = PW + 1;            // difference term
  localparam int MW  = DFW + GW + 1;      // scaled increment
  localparam int SHW = $clog2(MW);
  localparam logic signed [MW-1:0] VMAX = {{(MW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [MW-1:0] VMIN = {{(MW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // Shadow configuration
  logic signed [DW-1:0] restS, thrS;
  logic        [DW-1:0] resS;
  logic        [GW-1:0] gainS;

  always_ff @(posedge clk) begin
    if (st.loadCfg) begin
      restS <= cfgRest;
      thrS  <= cfgThresh;
      resS  <= cfgResist;
      gainS <= cfgGain;
    end
  end

  // Drive term I*R, back to Q8.8 with floor rounding
  logic signed [PW-1:0]  curX, resX, driveFull, driveQ;
  logic signed [DFW-1:0] diff;
  logic signed [MW-1:0]  diffX, inc, sum;
  logic signed [DW-1:0]  satV;

  always_comb begin
    curX      = PW'(inCurrent);
    resX      = PW'({1'b0, resS});
    driveFull = curX * resX;
    driveQ    = driveFull >>> FRAC;
    diff      = DFW'(driveQ) - (DFW'(potential) - DFW'(restS));
    diffX     = MW'(diff);
  end

  generate
    if (USE_SHIFT) begin : g_shiftGain
      always_comb inc = diffX >>> gainS[SHW-1:0];
    end else begin : g_mulGain
      logic signed [MW-1:0] gainX, prod;
      always_comb begin
        gainX = MW'({1'b0, gainS});
        prod  = diffX * gainX;
        inc   = prod >>> GW;
      end
    end
  endgenerate

  always_comb begin
    sum = MW'(potential) + inc;
    if (sum > VMAX)      satV = DW'(VMAX);
    else if (sum < VMIN) satV = DW'(VMIN);
    else                 satV = DW'(sum);
    fire = st.doStep && (satV >= thrS);
  end

  always_ff @(posedge clk) begin
    if (st.resetPot)   potential <= cfgRest;
    else if (st.doStep) potential <= fire ? restS : satV;
  end

  AST_FIRE_TO_REST: assert property (@(posedge clk) disable iff (st.resetPot)
    (st.doStep && fire) |=> (potential == $past(restS))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (st.resetPot)
    (!st.doStep) |=> $stable(potential)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (st.resetPot)
    (!st.loadCfg) |=> ($stable(thrS) && $stable(gainS) && $stable(restS))); // R10

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (st.resetPot)
    (st.doStep && !fire && diff > 0) |=> (potential >= $past(potential))); // R9

endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int DW        = 16,
  parameter int FRAC      = 8,
  parameter int GW        = 16,
  parameter bit USE_SHIFT = 1'b0
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stepEn,
  input  logic signed [DW-1:0] inCurrent,
  input  logic signed [DW-1:0] cfgRest,
  input  logic signed [DW-1:0] cfgThresh,
  input  logic        [DW-1:0] cfgResist,
  input  logic        [GW-1:0] cfgGain,
  output logic                 spike,
  output logic signed [DW-1:0] potential
);

  lifStrobes_t st;
  logic        fire;

  lif_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stepEn (stepEn),
    .fire   (fire),
    .st     (st),
    .spike  (spike)
  );

  lif_datapath #(
    .DW        (DW),
    .FRAC      (FRAC),
    .GW        (GW),
    .USE_SHIFT (USE_SHIFT)
  ) u_dp (
    .clk       (clk),
    .st        (st),
    .inCurrent (inCurrent),
    .cfgRest   (cfgRest),
    .cfgThresh (cfgThresh),
    .cfgResist (cfgResist),
    .cfgGain   (cfgGain),
    .fire      (fire),
    .potential (potential)
  );

endmodule

// File: tb/lif_neuron_test.sv
`timescale 1ns/1ps
module lif_neuron_test;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic stepEn = 1'b0;
  logic signed [15:0] inCurrent = '0;
  logic signed [15:0] cfgRest = -16'sd17920;
  logic signed [15:0] cfgThresh = -16'sd12800;
  logic [15:0] cfgResist = 16'd2560;
  logic [15:0] cfgGain = 16'd655;
  logic spike;
  logic signed [15:0] potential;

  always #2 clk = ~clk;  // 250 MHz

  lif_neuron uut (
    .clk(clk), .rst(rst), .stepEn(stepEn), .inCurrent(inCurrent),
    .cfgRest(cfgRest), .cfgThresh(cfgThresh), .cfgResist(cfgResist),
    .cfgGain(cfgGain), .spike(spike), .potential(potential)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R2";

  // Reference model state (effective configuration at step time)
  longint mV, mRest, mThr, mRes, mGain, mI;
  longint expPotQ[$];
  bit     expSpkQ[$];
  longint lastPot;
  bit     stepSeen = 1'b0;
  int     spikeCount = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void modelStep(output longint v, output bit f);
    longint drive, diff, inc, s;
    drive = (mI * mRes) >>> 8;
    diff  = drive - (mV - mRest);
    inc   = (diff * mGain) >>> 16;
    s     = mV + inc;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    f = (s >= mThr);
    mV = f ? mRest : s;
    v = mV;
  endfunction

  function automatic void syncModel();
    mRest = cfgRest; mThr = cfgThresh; mRes = cfgResist; mGain = cfgGain;
    mI = inCurrent;
  endfunction

  // Driver: one step, expected result pushed into the scoreboard
  task automatic doStep();
    longint v; bit f;
    syncModel();
    modelStep(v, f);
    expPotQ.push_back(v);
    expSpkQ.push_back(f);
    @(negedge clk) stepEn = 1'b1;
    @(negedge clk) stepEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mV = cfgRest;
    lastPot = cfgRest;
    rst = 1'b0;
  endtask

  always @(posedge clk) stepSeen <= stepEn && !rst;

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stepSeen) begin
        if (expPotQ.size() == 0) begin
          check(1'b0, "R2", potential, 0);
        end else begin
          longint ep; bit es;
          ep = expPotQ.pop_front();
          es = expSpkQ.pop_front();
          check(potential == ep, curReq, potential, ep);
          check(spike == es, "R6", spike, es);
          if (spike) spikeCount++;
          lastPot = ep;
        end
      end else begin
        check(spike == 1'b0, "R6", spike, 0);
        check(potential == lastPot, "R2", potential, lastPot);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int firstSpike, secondSpike, thirdSpike, stepIdx;
    doReset();
    // R1: reset state
    @(negedge clk);
    check(potential == -17920, "R1", potential, -17920);
    check(spike == 1'b0, "R1", spike, 0);

    // R3: zero drive holds at rest
    curReq = "R3";
    for (int k = 0; k < 20; k++) doStep();
    check(potential == -17920, "R3", potential, -17920);

    // R2: first step with drive 2.5
    curReq = "R2";
    inCurrent = 16'sd640;
    doStep();
    check(potential == -17857, "R2", potential, -17857);

    // R7: periodic firing
    curReq = "R7";
    firstSpike = -1; secondSpike = -1; thirdSpike = -1; stepIdx = 0;
    spikeCount = 0;
    for (int k = 0; k < 520; k++) begin
      doStep();
      stepIdx++;
      if (spike) begin
        if (firstSpike < 0) firstSpike = stepIdx;
        else if (secondSpike < 0) secondSpike = stepIdx;
        else if (thirdSpike < 0) thirdSpike = stepIdx;
      end
    end
    check(thirdSpike > 0, "R7", thirdSpike, 1);
    check((secondSpike - firstSpike) == (thirdSpike - secondSpike), "R7",
          thirdSpike - secondSpike, secondSpike - firstSpike);

    // R8: sub-threshold drive never fires
    curReq = "R8";
    inCurrent = 16'sd384;
    doReset();
    spikeCount = 0;
    for (int k = 0; k < 600; k++) doStep();
    check(spikeCount == 0, "R8", spikeCount, 0);

    // R4 / R5: exact threshold hit with half gain
    curReq = "R4";
    cfgRest = 16'sd0; cfgThresh = 16'sd256; cfgResist = 16'd512;
    cfgGain = 16'd32768; inCurrent = 16'sd256;
    doReset();
    doStep();
    check(spike == 1'b1, "R4", spike, 1);
    check(potential == 0, "R5", potential, 0);
    cfgThresh = 16'sd257;
    doStep();
    check(spike == 1'b0, "R4", spike, 0);
    check(potential == 256, "R4", potential, 256);
    curReq = "R5";
    doStep();
    check(spike == 1'b1, "R5", spike, 1);
    doStep();
    check(potential == 256, "R5", potential, 256);

    // R9: negative saturation
    curReq = "R9";
    cfgRest = 16'sd0; cfgThresh = 16'sd32767; cfgResist = 16'd65535;
    cfgGain = 16'd65535; inCurrent = -16'sd32768;
    doReset();
    doStep();
    check(potential == -32768, "R9", potential, -32768);
    doStep();
    check(potential == -32768, "R9", potential, -32768);

    // R10: config changed in the step cycle is not used by that step
    curReq = "R10";
    cfgRest = -16'sd17920; cfgThresh = -16'sd12800; cfgResist = 16'd2560;
    cfgGain = 16'd655; inCurrent = 16'sd640;
    doReset();
    begin
      longint v; bit f;
      syncModel();
      modelStep(v, f);
      expPotQ.push_back(v);
      expSpkQ.push_back(f);
      @(negedge clk);
      stepEn = 1'b1;
      cfgGain = 16'd0;
      @(negedge clk) stepEn = 1'b0;
      check(potential == -17857, "R10", potential, -17857);
    end
    doStep();
    check(potential == -17857, "R10", potential, -17857);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule